// File: doc/BRIEF.md
# Cache Array Maintenance Port

This block holds the tag and data storage of a 4-way set-associative operand cache with 16-byte lines. It lets software reach both arrays directly through memory-mapped reads and writes. Each access carries a 32-bit address and, for writes, a 32-bit data word. One address bit picks the data array or the tag array. A second address bit picks how a tag-array write behaves:

- **Direct write.** It overwrites tag, LRU, dirty and valid state in one named way.
- **Associative write.** It looks for the data word's tag across all four ways of a set. Only the valid and dirty bits of the matching way change.

Before either kind of tag write changes a line that is both valid and dirty, the port asks external memory to take the old line. It raises a write-back request with the old line address and all four longwords. It then stalls further accesses until the memory acknowledges, and only after that acknowledge does it commit the new tag state. Reads return their word one cycle after they are accepted.

Top module: `cache_maint_port`

## Requirements
- R1: After reset every valid and dirty bit is 0, req_ready is 1, and wb_req and rsp_valid are 0. A tag read of any slot returns 0 in bits 1:0.
- R2: Address bit 24 selects the array (1 = data, 0 = tag). Bits 9:4 give the set index and bits 13:12 give the way (00 to 11 for ways 0 to 3). For the data array, bits 3:2 give the longword within the line (00 to 11 for longwords 0 to 3), and bits 1:0 are ignored.
- R3: A tag write with address bit 3 = 0 (direct) stores four fields from the data word into the addressed set and way: tag from bits 31:10, LRU from bits 7:2, dirty from bit 1 and valid from bit 0. A tag read returns the same packing with bits 9:8 at zero. rsp_valid is high for exactly the cycle after a read is accepted.
- R4: Whenever a tag write stores valid = 0, the stored dirty bit is 0, whatever data bit 1 holds.
- R5: A direct write whose target line is valid and dirty raises wb_req in the cycle after acceptance. wb_addr is {old tag, index, 4'b0000}. wb_data holds longword n of the line in bits 32n+31:32n. The new tag state is stored only at the clock edge where wb_ack is sampled high.
- R6: A tag write with address bit 3 = 1 (associative) compares data bits 31:10 with the tag of every valid way in the addressed set. The lowest-numbered matching way takes the new dirty and valid bits. Its tag and LRU bits stay unchanged, and so do all other ways.
- R7: An associative write that matches no valid way changes no state and raises no write-back.
- R8: An associative write whose matching way is dirty raises a write-back of that way's line, with the same format and commit timing as R5.
- R9: A data-array write stores the 32-bit data word at the addressed way, set and longword. A data-array read returns it. Data-array accesses never change tag-array state and never raise wb_req.
- R10: While wb_req is high, req_ready is 0 and any request presented is ignored, so no read response is produced for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Maintenance access request |
| req_ready | output | 1 | Port can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Access address (array, index, way, longword, associative bits) |
| req_wdata | input | 32 | Write data word |
| rsp_valid | output | 1 | Read data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| wb_req | output | 1 | Write-back of an evicted dirty line pending |
| wb_ack | input | 1 | Memory has taken the write-back line |
| wb_addr | output | 32 | Byte address of the line being written back |
| wb_data | output | 128 | Four longwords of the line being written back |

## Verification
The assertions check the handshake rules on every cycle:
- req_ready stays low for as long as a write-back is pending.
- wb_req and wb_addr hold until the acknowledge arrives.
- A write-back starts only from an accepted tag write.
- rsp_valid follows exactly the accepted reads.
- No slot is ever dirty without being valid.

The bench scenarios are the only place the stored values themselves are shown correct. It sweeps every data word and every tag slot. It replaces dirty lines and compares the write-back address and line contents. It makes associative hits, misses and duplicate-tag hits and compares the resulting tag, LRU, dirty and valid fields against a model. It also presents a request during a stall to show that the request is dropped.

// File: rtl/cache_maint_port.sv
module cache_maint_port #(
  parameter int INDEX_W   = 6,
  parameter int TAG_W     = 22,
  parameter int LRU_W     = 6,
  parameter int WAY_LSB   = 12,
  parameter int ASSOC_BIT = 3,
  parameter int ARRAY_BIT = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [31:0]              req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  output logic [31:0]              rsp_rdata,
  output logic                     wb_req,
  input  logic                     wb_ack,
  output logic [TAG_W+INDEX_W+3:0] wb_addr,
  output logic [127:0]             wb_data
);
  localparam int WAYS   = 4;
  localparam int SLOT_W = 2 + INDEX_W;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int WORD_W = SLOT_W + 2;
  localparam int WORDS  = 1 << WORD_W;

  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [LRU_W-1:0] lru_q [SLOTS];
  logic [31:0]      data_q [WORDS];
  logic [SLOTS-1:0] v_q, u_q;
  logic             busy_q;

  logic [INDEX_W-1:0] a_idx;
  logic [1:0]         a_way, a_lw;
  logic               a_data, a_assoc;
  logic [TAG_W-1:0]   w_tag;
  logic [LRU_W-1:0]   w_lru;
  logic               w_v, w_u;

  assign a_data  = req_addr[ARRAY_BIT];
  assign a_assoc = req_addr[ASSOC_BIT];
  assign a_idx   = req_addr[INDEX_W+3:4];
  assign a_way   = req_addr[WAY_LSB+1:WAY_LSB];
  assign a_lw    = req_addr[3:2];
  assign w_tag   = req_wdata[31:32-TAG_W];
  assign w_lru   = req_wdata[LRU_W+1:2];
  assign w_v     = req_wdata[0];
  assign w_u     = req_wdata[1] & req_wdata[0];

  logic unused_bits;
  assign unused_bits = ^{req_addr, req_wdata};

  logic [WAYS-1:0] hit;
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    logic [SLOT_W-1:0] s;
    assign s      = {2'(g), a_idx};
    assign hit[g] = v_q[s] && (tag_q[s] == w_tag);
  end

  logic [1:0] hit_way;
  always_comb begin
    hit_way = '0;
    for (int k = WAYS - 1; k >= 0; k--)
      if (hit[k]) hit_way = k[1:0];
  end

  logic [SLOT_W-1:0] tgt, rslot;
  logic accept, tag_wr, upd, need_wb;
  assign tgt       = {a_assoc ? hit_way : a_way, a_idx};
  assign rslot     = {a_way, a_idx};
  assign req_ready = ~busy_q;
  assign accept    = req_valid & ~busy_q;
  assign tag_wr    = accept & req_write & ~a_data;
  assign upd       = tag_wr & (~a_assoc | (|hit));
  assign need_wb   = upd & u_q[tgt] & v_q[tgt];
  assign wb_req    = busy_q;

  logic [SLOT_W-1:0] p_slot;
  logic              p_assoc, p_u, p_v;
  logic [TAG_W-1:0]  p_tag;
  logic [LRU_W-1:0]  p_lru;

  logic              c_en, c_assoc, c_u, c_v;
  logic [SLOT_W-1:0] c_slot;
  logic [TAG_W-1:0]  c_tag;
  logic [LRU_W-1:0]  c_lru;
  assign c_en    = busy_q ? wb_ack  : (upd & ~need_wb);
  assign c_slot  = busy_q ? p_slot  : tgt;
  assign c_assoc = busy_q ? p_assoc : a_assoc;
  assign c_tag   = busy_q ? p_tag   : w_tag;
  assign c_lru   = busy_q ? p_lru   : w_lru;
  assign c_u     = busy_q ? p_u     : w_u;
  assign c_v     = busy_q ? p_v     : w_v;

  logic [31:0] tag_word;
  always_comb begin
    tag_word                  = '0;
    tag_word[31:32-TAG_W]     = tag_q[rslot];
    tag_word[LRU_W+1:2]       = lru_q[rslot];
    tag_word[1]               = u_q[rslot];
    tag_word[0]               = v_q[rslot];
  end

  always_ff @(posedge clk) begin
    if (accept && req_write && a_data)
      data_q[{a_way, a_idx, a_lw}] <= req_wdata;
    if (c_en && !c_assoc) begin
      tag_q[c_slot] <= c_tag;
      lru_q[c_slot] <= c_lru;
    end
    if (accept && !req_write)
      rsp_rdata <= a_data ? data_q[{a_way, a_idx, a_lw}] : tag_word;
    if (need_wb) begin
      p_slot  <= tgt;
      p_assoc <= a_assoc;
      p_tag   <= w_tag;
      p_lru   <= w_lru;
      p_u     <= w_u;
      p_v     <= w_v;
      wb_addr <= {tag_q[tgt], a_idx, 4'b0000};
      wb_data <= {data_q[{tgt, 2'd3}], data_q[{tgt, 2'd2}],
                  data_q[{tgt, 2'd1}], data_q[{tgt, 2'd0}]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      rsp_valid <= 1'b0;
      v_q       <= '0;
      u_q       <= '0;
    end else begin
      rsp_valid <= accept & ~req_write;
      if (need_wb)              busy_q <= 1'b1;
      else if (busy_q && wb_ack) busy_q <= 1'b0;
      if (c_en) begin
        v_q[c_slot] <= c_v;
        u_q[c_slot] <= c_u;
      end
    end
  end
endmodule

module cache_maint_port_chk #(
  parameter int SLOTS     = 256,
  parameter int AW        = 32,
  parameter int ARRAY_BIT = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [31:0]      req_addr,
  input logic             rsp_valid,
  input logic             wb_req,
  input logic             wb_ack,
  input logic [AW-1:0]    wb_addr,
  input logic [SLOTS-1:0] v_q,
  input logic [SLOTS-1:0] u_q
);
  a_r10_stall_while_wb: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> !req_ready);
  a_r5_wb_held: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req);
  a_r5_wb_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> $stable(wb_addr));
  a_r3_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);
  a_r3_rsp_only_for_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));
  a_r4_no_dirty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (u_q & ~v_q) == '0);
  a_r9_wb_from_tag_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(req_valid && req_ready && req_write && !req_addr[ARRAY_BIT]));
endmodule

bind cache_maint_port cache_maint_port_chk #(
  .SLOTS(1 << (INDEX_W + 2)), .AW(TAG_W + INDEX_W + 4), .ARRAY_BIT(ARRAY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr), .v_q(v_q), .u_q(u_q)
);

// File: tb/test_cache_maint_port.sv
module test_cache_maint_port;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, wb_ack = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic req_ready, rsp_valid, wb_req;
  logic [31:0] rsp_rdata, wb_addr;
  logic [127:0] wb_data;

  always #5 clk = ~clk;

  cache_maint_port i_cache_maint_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wb_req(wb_req),
    .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_data(wb_data));

  int checks = 0, fails = 0;
  logic [21:0] m_tag [256];
  logic [5:0]  m_lru [256];
  logic        m_u [256], m_v [256];
  logic [31:0] m_data [1024];

  task automatic chk(string r, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] taddr(int way, int idx, bit assoc);
    return (way << 12) | (idx << 4) | (32'(assoc) << 3);
  endfunction
  function automatic logic [31:0] daddr(int way, int idx, int lw);
    return (32'd1 << 24) | (way << 12) | (idx << 4) | (lw << 2);
  endfunction
  function automatic logic [31:0] tword(logic [21:0] t, logic [5:0] l, bit u, bit v);
    return {t, 2'b00, l, u, v};
  endfunction

  task automatic rd(logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R3 rsp_valid", rsp_valid, 1);
    d = rsp_rdata;
  endtask

  task automatic wr_data(int way, int idx, int lw, logic [31:0] val, logic [1:0] low);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = daddr(way, idx, lw) | low; req_wdata = val;
    @(negedge clk);
    req_valid = 0;
    chk("R9 no wb on data write", wb_req, 0);
    m_data[way*256 + idx*4 + lw] = val;
  endtask

  task automatic wr_tag(int way, int idx, bit assoc, logic [31:0] d);
    int tgt = -1;
    bit ewb;
    if (!assoc) tgt = way*64 + idx;
    else for (int w = 3; w >= 0; w--)
      if (m_v[w*64+idx] && m_tag[w*64+idx] == d[31:10]) tgt = w*64 + idx;
    ewb = (tgt >= 0) && m_u[tgt] && m_v[tgt];
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = taddr(way, idx, assoc); req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    if (ewb) begin
      chk(assoc ? "R8 wb_req" : "R5 wb_req", wb_req, 1);
      chk("R10 ready low", req_ready, 0);
      chk("R5 wb_addr", wb_addr, {m_tag[tgt], 6'(idx), 4'b0});
      chk("R5 wb_data", wb_data, {m_data[tgt*4+3], m_data[tgt*4+2],
                                  m_data[tgt*4+1], m_data[tgt*4]});
      req_valid = 1; req_write = 0; req_addr = taddr(0, 0, 0);
      @(negedge clk);
      chk("R10 ignored req", rsp_valid, 0);
      chk("R5 held", wb_req, 1);
      @(negedge clk);
      chk("R10 ignored req", rsp_valid, 0);
      req_valid = 0; wb_ack = 1;
      @(negedge clk);
      wb_ack = 0;
      chk("R5 released", wb_req, 0);
      chk("R5 ready back", req_ready, 1);
    end else begin
      chk(assoc && tgt < 0 ? "R7 no wb" : "R5 no wb", wb_req, 0);
    end
    if (tgt >= 0) begin
      if (!assoc) begin m_tag[tgt] = d[31:10]; m_lru[tgt] = d[7:2]; end
      m_v[tgt] = d[0];
      m_u[tgt] = d[1] & d[0];
    end
  endtask

  task automatic check_all_tags(string r);
    logic [31:0] d;
    for (int s = 0; s < 256; s++) begin
      rd(taddr(s / 64, s % 64, 0), d);
      chk(r, d, tword(m_tag[s], m_lru[s], m_u[s], m_v[s]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 wb_req", wb_req, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1;
    for (int s = 0; s < 256; s++) begin m_u[s] = 0; m_v[s] = 0; end
    for (int s = 0; s < 256; s++) begin
      rd(taddr(s / 64, s % 64, 0), d);
      chk("R1 V/U clear", d[1:0], 0);
    end

    // R2 R9: every data word, with junk in address bits 1:0
    for (int i = 0; i < 1024; i++)
      wr_data(i / 256, (i / 4) % 64, i % 4, i * 32'h9E3779B1 ^ 32'h5A5A0F0F, 2'(i));
    for (int i = 0; i < 1024; i++) begin
      rd(daddr(i / 256, (i / 4) % 64, i % 4), d);
      chk("R9 data readback", d, m_data[i]);
    end
    for (int s = 0; s < 256; s += 7) begin
      rd(taddr(s / 64, s % 64, 0), d);
      chk("R9 tags untouched", d[1:0], 0);
    end

    // R3 R4: direct fill, V=0 entries written with U=1
    for (int s = 0; s < 256; s++)
      wr_tag(s / 64, s % 64, 0,
             tword(22'(s * 40503 + 4660), 6'(s ^ 5), s % 2 == 1, s % 3 != 0));
    check_all_tags("R3 R4 direct readback");

    // R5: replace lines, dirty valid ones write back first
    for (int s = 0; s < 256; s += 5)
      wr_tag(s / 64, s % 64, 0, tword(22'(s * 977 + 3), 6'(63 - s % 64), s % 4 == 1, 1'b1));
    check_all_tags("R5 after replacement");

    // R6 R7 R8: associative hits on each valid way, then misses
    for (int idx = 0; idx < 64; idx++) begin
      for (int w = 0; w < 4; w++)
        if (m_v[w*64+idx])
          wr_tag(w ^ 2, idx, 1, {m_tag[w*64+idx], 2'b11, 6'h2A, (idx + w) % 2 == 1, (idx + w) % 3 != 1});
      wr_tag(0, idx, 1, tword(22'h3FFFFF - 22'(idx), 6'h15, 1'b1, 1'b1));
    end
    check_all_tags("R6 R7 R8 assoc readback");

    // R6: duplicate tag in ways 1 and 3, lowest way takes the update
    wr_tag(0, 5, 0, tword(22'h00ABC, 6'd1, 0, 0));
    wr_tag(1, 5, 0, tword(22'h12345, 6'd2, 0, 1));
    wr_tag(2, 5, 0, tword(22'h00DEF, 6'd3, 0, 0));
    wr_tag(3, 5, 0, tword(22'h12345, 6'd4, 0, 1));
    wr_tag(0, 5, 1, tword(22'h12345, 6'd9, 1, 1));
    rd(taddr(1, 5, 0), d); chk("R6 lowest way hit", d, tword(22'h12345, 6'd2, 1, 1));
    rd(taddr(3, 5, 0), d); chk("R6 other way unchanged", d, tword(22'h12345, 6'd4, 0, 1));
    wr_tag(2, 5, 1, tword(22'h12345, 6'd0, 1, 0));
    rd(taddr(1, 5, 0), d); chk("R4 R8 invalidated", d, tword(22'h12345, 6'd2, 0, 0));
    wr_tag(0, 5, 1, tword(22'h12345, 6'd0, 1, 1));
    rd(taddr(3, 5, 0), d); chk("R6 next way hit", d, tword(22'h12345, 6'd4, 1, 1));
    check_all_tags("R6 final readback");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule